// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a 48-bit virtual address to a 52-bit physical address when a translation cache has missed. It starts from a 40-bit root frame number and visits four levels of tables. At each level it reads one 64-bit entry over a simple request/response memory port and checks that entry. When the entry is valid but its accessed flag is clear, the block sets the flag and writes the entry back. On the last level of a store it sets the dirty flag as well. Each write-back finishes before the next level is read.

A walk ends in one of two ways. It can return the physical address together with its permission and cache attributes. Or it can stop with a fault code: the entry is not present, the access is not permitted, or the first-level entry asks for a large page, which this block does not support. The requester presents one walk at a time and waits for a one-cycle completion pulse.

Top module: `pt_walker`

## Requirements
- R1: After reset `done` and `mem_req_valid` are low and `req_ready` is high.
- R2: Levels are visited from the most significant 9-bit index (vaddr[47:39]) down to vaddr[20:12]. The entry address is the table frame number shifted left by 12 plus the index times 8. Level one uses `root_pfn`, and every later level uses bits [51:12] of the entry read before it.
- R3: An entry with bit 0 (present) clear ends the walk with fault code 1. No further memory access follows, not even a write-back of that entry.
- R4: A store (`req_write`=1) through an entry with bit 1 (writable) clear, or a user access (`req_user`=1) through an entry with bit 2 (user) clear, ends the walk with fault code 2. The faulting entry is not written.
- R5: A first-level entry with bit 7 (large page) set ends the walk with fault code 3.
- R6: An entry that passes its checks and has bit 5 (accessed) clear is written back to the same address with bit 5 set. The write completes before the next read. An entry whose bit 5 is already set is not written. No write ever clears a bit.
- R7: On a store, the last-level entry is written with bit 6 (dirty) set, in the same write that sets bit 5 if that bit was clear. On a load, bit 6 is never set.
- R8: On success the fault code is 0, and `paddr` is bits [51:12] of the last-level entry followed by vaddr[11:0]. `attr_writable` and `attr_user` are the AND of bits 1 and 2 over all four levels. `attr_wt`, `attr_cd` and `attr_global` are bits 3, 4 and 8 of the last-level entry.
- R9: `done` is high for exactly one cycle per walk. A request is accepted only while `req_ready` is high, and a request raised during a walk has no effect on that walk.
- R10: A memory request stays asserted with a stable address, direction and data until `mem_req_ready` accepts it. Each accepted request completes on one `mem_rsp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 48 | Virtual address to translate |
| req_write | input | 1 | Access is a store |
| req_user | input | 1 | Access is from user mode |
| root_pfn | input | 40 | Frame number of the first-level table |
| mem_req_valid | output | 1 | Memory request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is an entry write-back |
| mem_req_addr | output | 52 | Physical byte address of the entry |
| mem_req_wdata | output | 64 | Entry value to write |
| mem_rsp_valid | input | 1 | Memory response (read data or write completion) |
| mem_rsp_rdata | input | 64 | Entry read data |
| done | output | 1 | One-cycle walk completion |
| fault_code | output | 2 | 0 ok, 1 not present, 2 protection, 3 large page |
| paddr | output | 52 | Translated physical address |
| attr_writable | output | 1 | Store permitted on every level |
| attr_user | output | 1 | User access permitted on every level |
| attr_wt | output | 1 | Last-level write-through |
| attr_cd | output | 1 | Last-level cache disable |
| attr_global | output | 1 | Last-level global |

## Verification
Setting the accessed flag and setting the dirty flag can fall on the same last-level write-back. A permission fault can also hit an entry whose accessed flag is clear, so fault detection and the flag update compete in one evaluation. The bench provokes the first case with a store through a last-level entry that has both flags clear. It judges the case by the single write in the memory log and by the stored entry, which must show both bits. It provokes the second case with a store through a read-only entry that has no accessed flag. Here the log must end at that read and the entry in memory must be unchanged.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    // entry flag positions (fixed by the table format)
    localparam int BIT_PRESENT = 0;
    localparam int BIT_WRITE   = 1;
    localparam int BIT_USER    = 2;
    localparam int BIT_WT      = 3;
    localparam int BIT_CD      = 4;
    localparam int BIT_ACC     = 5;
    localparam int BIT_DIRTY   = 6;
    localparam int BIT_BIG     = 7;
    localparam int BIT_GLOBAL  = 8;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_ABSENT  = 2'd1,
        FLT_PROTECT = 2'd2,
        FLT_BIGPAGE = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_EVAL,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_NEXT,
        ST_DONE
    } walk_state_e;

    typedef struct packed {
        logic writable;
        logic user;
        logic wt;
        logic cd;
        logic glb;
    } attr_t;

endpackage

// File: rtl/ptw_idx_sel.sv
module ptw_idx_sel #(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int PFN_W  = 40,
    localparam int LVL_W = $clog2(LEVELS),
    localparam int SH_W  = OFF_W - IDX_W
) (
    input  logic [LEVELS*IDX_W-1:0] vpn,
    input  logic [LVL_W-1:0]        level,
    input  logic [PFN_W-1:0]        base_pfn,
    output logic [PFN_W+OFF_W-1:0]  entry_addr
);
    logic [IDX_W-1:0] idx_arr [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_split
        assign idx_arr[g] = vpn[(LEVELS-g)*IDX_W-1 -: IDX_W];
    end

    assign entry_addr = {base_pfn, idx_arr[level], {SH_W{1'b0}}};
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
    import ptw_pkg::*;
#(
    parameter int PTE_W = 64,
    parameter int PFN_W = 40,
    parameter int OFF_W = 12
) (
    input  logic [PTE_W-1:0] entry,
    input  logic             is_first,
    input  logic             is_last,
    input  logic             acc_write,
    input  logic             acc_user,
    output fault_e           fault,
    output logic [PTE_W-1:0] updated,
    output logic             need_wb,
    output logic [PFN_W-1:0] next_pfn
);
    logic [PTE_W-1:0] set_mask;

    always_comb begin
        if (!entry[BIT_PRESENT])
            fault = FLT_ABSENT;
        else if (is_first && entry[BIT_BIG])
            fault = FLT_BIGPAGE;
        else if ((acc_write && !entry[BIT_WRITE]) || (acc_user && !entry[BIT_USER]))
            fault = FLT_PROTECT;
        else
            fault = FLT_NONE;
    end

    always_comb begin
        set_mask = '0;
        set_mask[BIT_ACC]   = 1'b1;
        set_mask[BIT_DIRTY] = is_last && acc_write;
    end

    assign updated  = entry | set_mask;
    assign need_wb  = (fault == FLT_NONE) && (updated != entry);
    assign next_pfn = entry[OFF_W+PFN_W-1:OFF_W];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int PFN_W  = 40,
    parameter int PTE_W  = 64,
    localparam int VA_W  = LEVELS*IDX_W + OFF_W,
    localparam int PA_W  = PFN_W + OFF_W,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             req_user,
    input  logic [PFN_W-1:0] root_pfn,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             mem_req_write,
    output logic [PA_W-1:0]  mem_req_addr,
    output logic [PTE_W-1:0] mem_req_wdata,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_rdata,
    output logic             done,
    output logic [1:0]       fault_code,
    output logic [PA_W-1:0]  paddr,
    output logic             attr_writable,
    output logic             attr_user,
    output logic             attr_wt,
    output logic             attr_cd,
    output logic             attr_global
);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS-1);

    walk_state_e      state;
    logic [LVL_W-1:0] level;
    logic [VA_W-1:0]  vaddr_q;
    logic             wr_q, user_q;
    logic [PFN_W-1:0] base_q;
    logic [PTE_W-1:0] entry_q;
    logic             rw_acc, us_acc;
    attr_t            attr_q;
    fault_e           fault_q;
    logic [PA_W-1:0]  paddr_q;

    fault_e           ev_fault;
    logic [PTE_W-1:0] ev_updated;
    logic             ev_need_wb;
    logic [PFN_W-1:0] ev_next_pfn;
    logic [PA_W-1:0]  entry_addr;

    ptw_idx_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PFN_W(PFN_W)) u_idx (
        .vpn        (vaddr_q[VA_W-1:OFF_W]),
        .level      (level),
        .base_pfn   (base_q),
        .entry_addr (entry_addr)
    );

    ptw_entry_eval #(.PTE_W(PTE_W), .PFN_W(PFN_W), .OFF_W(OFF_W)) u_eval (
        .entry     (entry_q),
        .is_first  (level == '0),
        .is_last   (level == LAST_LVL),
        .acc_write (wr_q),
        .acc_user  (user_q),
        .fault     (ev_fault),
        .updated   (ev_updated),
        .need_wb   (ev_need_wb),
        .next_pfn  (ev_next_pfn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            level   <= '0;
            vaddr_q <= '0;
            wr_q    <= 1'b0;
            user_q  <= 1'b0;
            base_q  <= '0;
            entry_q <= '0;
            rw_acc  <= 1'b1;
            us_acc  <= 1'b1;
            attr_q  <= '0;
            fault_q <= FLT_NONE;
            paddr_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        wr_q    <= req_write;
                        user_q  <= req_user;
                        base_q  <= root_pfn;
                        level   <= '0;
                        rw_acc  <= 1'b1;
                        us_acc  <= 1'b1;
                        fault_q <= FLT_NONE;
                        attr_q  <= '0;
                        paddr_q <= '0;
                        state   <= ST_RD_REQ;
                    end
                end
                ST_RD_REQ:  if (mem_req_ready) state <= ST_RD_WAIT;
                ST_RD_WAIT: begin
                    if (mem_rsp_valid) begin
                        entry_q <= mem_rsp_rdata;
                        state   <= ST_EVAL;
                    end
                end
                ST_EVAL: begin
                    if (ev_fault != FLT_NONE) begin
                        fault_q <= ev_fault;
                        state   <= ST_DONE;
                    end else begin
                        rw_acc <= rw_acc & entry_q[BIT_WRITE];
                        us_acc <= us_acc & entry_q[BIT_USER];
                        state  <= ev_need_wb ? ST_WR_REQ : ST_NEXT;
                    end
                end
                ST_WR_REQ:  if (mem_req_ready) state <= ST_WR_WAIT;
                ST_WR_WAIT: if (mem_rsp_valid) state <= ST_NEXT;
                ST_NEXT: begin
                    if (level == LAST_LVL) begin
                        paddr_q <= {ev_next_pfn, vaddr_q[OFF_W-1:0]};
                        attr_q  <= '{writable: rw_acc, user: us_acc,
                                     wt: entry_q[BIT_WT], cd: entry_q[BIT_CD],
                                     glb: entry_q[BIT_GLOBAL]};
                        state   <= ST_DONE;
                    end else begin
                        base_q <= ev_next_pfn;
                        level  <= level + 1'b1;
                        state  <= ST_RD_REQ;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_RD_REQ) || (state == ST_WR_REQ);
    assign mem_req_write = (state == ST_WR_REQ);
    assign mem_req_addr  = entry_addr;
    assign mem_req_wdata = ev_updated;
    assign done          = (state == ST_DONE);
    assign fault_code    = fault_q;
    assign paddr         = paddr_q;
    assign attr_writable = attr_q.writable;
    assign attr_user     = attr_q.user;
    assign attr_wt       = attr_q.wt;
    assign attr_cd       = attr_q.cd;
    assign attr_global   = attr_q.glb;

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_req_valid && !done));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    assert_wb_sets_acc_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> mem_req_wdata[BIT_ACC]);

    assert_wb_keeps_bits_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> ((mem_req_wdata & entry_q) == entry_q));

    assert_absent_no_wb_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EVAL && !entry_q[BIT_PRESENT]) |=> (done && fault_code == 2'd1));
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write, req_user;
    logic [47:0] req_vaddr;
    logic [39:0] root_pfn;
    logic        mem_req_valid, mem_req_write;
    logic        mem_req_ready;
    logic [51:0] mem_req_addr;
    logic [63:0] mem_req_wdata;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_rdata;
    logic        done;
    logic [1:0]  fault_code;
    logic [51:0] paddr;
    logic        attr_writable, attr_user, attr_wt, attr_cd, attr_global;

    always #2 clk = ~clk;

    pt_walker dut (.*);

    int checks = 0;
    int errors = 0;
    logic stall_mode = 1'b0;

    logic [63:0] pmem [logic [51:0]];
    logic        log_w [32];
    logic [51:0] log_a [32];
    logic [63:0] log_d [32];
    int          n_log = 0;

    localparam logic [39:0] ROOT = 40'h100;

    function automatic logic [63:0] rd(input logic [51:0] a);
        return pmem.exists(a) ? pmem[a] : 64'h0;
    endfunction

    function automatic logic [63:0] pte(input logic [39:0] pfn, input logic [11:0] fl);
        return {12'h0, pfn, fl};
    endfunction

    function automatic logic [39:0] tbl(input int l);
        return ROOT + 40'(l) * 40'h100;
    endfunction

    function automatic logic [51:0] eaddr(input logic [47:0] va, input int l);
        logic [8:0] ix;
        ix = va[47-9*l -: 9];
        return {tbl(l), ix, 3'b000};
    endfunction

    // memory model: accepts when ready, responds one cycle later
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        mem_req_ready <= stall_mode ? ~mem_req_ready : 1'b1;
        if (!rst && mem_req_valid && mem_req_ready) begin
            if (n_log < 32) begin
                log_w[n_log] = mem_req_write;
                log_a[n_log] = mem_req_addr;
                log_d[n_log] = mem_req_wdata;
                n_log++;
            end
            if (mem_req_write) pmem[mem_req_addr] = mem_req_wdata;
            else mem_rsp_rdata <= rd(mem_req_addr);
            mem_rsp_valid <= 1'b1;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic build(input logic [47:0] va, input logic [11:0] f1, input logic [11:0] f2,
                         input logic [11:0] f3, input logic [11:0] f4, input logic [39:0] page);
        pmem.delete();
        pmem[eaddr(va, 0)] = pte(tbl(1), f1);
        pmem[eaddr(va, 1)] = pte(tbl(2), f2);
        pmem[eaddr(va, 2)] = pte(tbl(3), f3);
        pmem[eaddr(va, 3)] = pte(page, f4);
    endtask

    task automatic walk(input logic [47:0] va, input logic wr, input logic usr, input int hold);
        int cyc;
        @(negedge clk);
        chk(req_ready, "R9 idle before walk", 64'(req_ready), 64'd1);
        n_log = 0;
        req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = usr;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            req_vaddr = ~va; req_write = ~wr;
        end
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done, "R9 walk completes", 64'(done), 64'd1);
        fork begin
            @(negedge clk);
            chk(!done, "R9 done lasts one cycle", 64'(done), 64'd0);
        end join_none
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!done && !mem_req_valid && req_ready, "R1 reset state",
            {61'd0, done, mem_req_valid, req_ready}, 64'd1);
    endtask

    task automatic t_basic_read();
        logic [47:0] va = {9'h011, 9'h022, 9'h033, 9'h044, 12'h5A5};
        build(va, 12'h007, 12'h007, 12'h007, 12'h007, 40'hABCDE);
        walk(va, 1'b0, 1'b1, 0);
        @(negedge clk);
        chk(n_log == 8, "R6 read+writeback per level", 64'(n_log), 64'd8);
        for (int l = 0; l < 4; l++) begin
            chk(!log_w[2*l] && log_a[2*l] == eaddr(va, l), "R2 read order/address",
                64'(log_a[2*l]), 64'(eaddr(va, l)));
            chk(log_w[2*l+1] && log_a[2*l+1] == eaddr(va, l) && log_d[2*l+1][11:0] == 12'h027,
                "R6 accessed writeback before next level", log_d[2*l+1], 64'h27);
        end
        chk(rd(eaddr(va, 3)) == pte(40'hABCDE, 12'h027), "R7 load leaves dirty clear",
            rd(eaddr(va, 3)), pte(40'hABCDE, 12'h027));
        chk(fault_code == 2'd0 && paddr == {40'hABCDE, 12'h5A5}, "R8 physical address",
            64'(paddr), 64'({40'hABCDE, 12'h5A5}));
    endtask

    task automatic t_no_rewrite_stall();
        logic [47:0] va = {9'h011, 9'h022, 9'h033, 9'h044, 12'h5A5};
        stall_mode = 1'b1;
        walk(va, 1'b0, 1'b1, 3);
        @(negedge clk);
        stall_mode = 1'b0;
        chk(n_log == 4, "R6 no write when accessed already set", 64'(n_log), 64'd4);
        chk(log_a[0] == eaddr(va, 0) && log_a[3] == eaddr(va, 3),
            "R10 R9 stalled handshake keeps addresses, busy request ignored",
            64'(log_a[3]), 64'(eaddr(va, 3)));
        chk(paddr == {40'hABCDE, 12'h5A5}, "R9 result from accepted request",
            64'(paddr), 64'({40'hABCDE, 12'h5A5}));
    endtask

    task automatic t_store_dirty();
        logic [47:0] va = {9'h1FF, 9'h000, 9'h155, 9'h0AA, 12'hFFF};
        build(va, 12'h027, 12'h027, 12'h027, 12'h007, 40'h12345);
        walk(va, 1'b1, 1'b0, 0);
        @(negedge clk);
        chk(n_log == 5, "R7 single final writeback", 64'(n_log), 64'd5);
        chk(log_w[4] && log_d[4][11:0] == 12'h067, "R7 accessed and dirty in one write",
            log_d[4], 64'h67);
        chk(paddr == {40'h12345, 12'hFFF} && fault_code == 2'd0, "R8 store translation",
            64'(paddr), 64'({40'h12345, 12'hFFF}));
    endtask

    task automatic t_absent();
        logic [47:0] va = {9'h003, 9'h004, 9'h005, 9'h006, 12'h010};
        build(va, 12'h027, 12'h027, 12'h026, 12'h027, 40'h1);
        walk(va, 1'b0, 1'b0, 0);
        @(negedge clk);
        chk(fault_code == 2'd1, "R3 not-present fault code", 64'(fault_code), 64'd1);
        chk(n_log == 3, "R3 walk stops at absent entry", 64'(n_log), 64'd3);
    endtask

    task automatic t_readonly();
        logic [47:0] va = {9'h007, 9'h008, 9'h009, 9'h00A, 12'h020};
        build(va, 12'h007, 12'h005, 12'h027, 12'h027, 40'h2);
        walk(va, 1'b1, 1'b0, 0);
        @(negedge clk);
        chk(fault_code == 2'd2, "R4 store through read-only", 64'(fault_code), 64'd2);
        chk(n_log == 3, "R4 no writeback of faulting entry", 64'(n_log), 64'd3);
        chk(rd(eaddr(va, 1)) == pte(tbl(2), 12'h005), "R4 faulting entry unchanged",
            rd(eaddr(va, 1)), pte(tbl(2), 12'h005));
    endtask

    task automatic t_supervisor();
        logic [47:0] va = {9'h0F0, 9'h0F1, 9'h0F2, 9'h0F3, 12'h030};
        build(va, 12'h027, 12'h027, 12'h027, 12'h023, 40'h3);
        walk(va, 1'b0, 1'b1, 0);
        @(negedge clk);
        chk(fault_code == 2'd2 && n_log == 4, "R4 user through supervisor entry",
            64'(fault_code), 64'd2);
        walk(va, 1'b0, 1'b0, 0);
        @(negedge clk);
        chk(fault_code == 2'd0 && attr_user == 1'b0, "R4 R8 supervisor access allowed",
            {62'd0, fault_code}, 64'd0);
    endtask

    task automatic t_bigpage();
        logic [47:0] va = {9'h100, 9'h101, 9'h102, 9'h103, 12'h040};
        build(va, 12'h0A7, 12'h027, 12'h027, 12'h027, 40'h4);
        walk(va, 1'b0, 1'b0, 0);
        @(negedge clk);
        chk(fault_code == 2'd3 && n_log == 1, "R5 large page fault", 64'(fault_code), 64'd3);
    endtask

    task automatic t_attrs();
        logic [47:0] va = {9'h033, 9'h066, 9'h099, 9'h0CC, 12'h123};
        build(va, 12'h027, 12'h025, 12'h027, 12'h13F, 40'hFEDCB);
        walk(va, 1'b0, 1'b0, 0);
        @(negedge clk);
        chk({attr_writable, attr_user, attr_wt, attr_cd, attr_global} == 5'b01111,
            "R8 attribute merge",
            64'({attr_writable, attr_user, attr_wt, attr_cd, attr_global}), 64'b01111);
        chk(n_log == 4 && paddr == {40'hFEDCB, 12'h123}, "R8 address with attributes",
            64'(paddr), 64'({40'hFEDCB, 12'h123}));
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_user = 1'b0;
        root_pfn = ROOT; mem_rsp_valid = 1'b0; mem_rsp_rdata = '0; mem_req_ready = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic_read();
        t_no_rewrite_stall();
        t_store_dirty();
        t_absent();
        t_readonly();
        t_supervisor();
        t_bigpage();
        t_attrs();
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule